// File: doc/BRIEF.md
# Byte-Order-Aware Load/Store Aligner

This block connects byte-addressed load and store requests to a memory port that moves one aligned 32-bit word per transfer. A request carries an address, a size (byte, halfword or word), store data, a byte-order select and a signed/unsigned select. The block turns each request into one or two word transfers with per-lane byte enables. For loads, it picks the addressed bytes out of the returned word or words, orders them as selected and widens the result to 32 bits.

An access is misaligned when its size does not divide its address. A mode input, sampled when the request is accepted, chooses what happens next. In split mode the block performs the access anyway, using the lower word first and then the next word when the bytes spill over. In fault mode it reports a one-cycle error and touches no memory. Requests use a valid/ready handshake. The memory side uses valid/ready with read data returned in the accepting cycle.

Top module: `endian_lsu`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_valid`, `done` and `misalign_err` are 0.
- R2: Every memory transfer has `mem_addr[1:0]` equal to 0. `mem_be` enables exactly the lanes whose byte addresses the request covers. Lane i of word address W holds byte address W+i, and `mem_be` bit i enables lane i.
- R3: In little-endian mode (`req_big`=0), byte k of the value (k=0 least significant) goes to or comes from byte address addr+k. A word store of 0x12345678 at an aligned address therefore writes the memory word 0x12345678.
- R4: In big-endian mode (`req_big`=1), byte k of an n-byte value is at byte address addr+n-1-k. A word store of 0x12345678 at an aligned address writes the memory word 0x78563412.
- R5: When `req_signed`=0, a load returns the value zero-extended to 32 bits. `req_size` encodes 0 as byte, 1 as halfword, and 2 or 3 as word.
- R6: When `req_signed`=1, a byte or halfword load copies the value's top bit into all upper bits of `rdata`.
- R7: A word access is misaligned unless addr[1:0]=0. A halfword access is misaligned when addr[0]=1. A byte access is never misaligned.
- R8: With `split_mode`=1, an access whose bytes span two words makes two transfers: the lower word first, then the word 4 bytes higher, each with its partial byte enables. `done` is raised only after the second transfer. An access inside one word uses one transfer.
- R9: With `split_mode`=0, a misaligned request raises `misalign_err` for one cycle, the cycle after acceptance. It makes no memory transfer and raises no `done`.
- R10: `req_ready` stays 0 while a transfer is outstanding. A memory request held with `mem_ready`=0 keeps its address, enables, data and direction stable.
- R11: `done` pulses for one cycle, the cycle after the last transfer is accepted. For loads, `rdata` carries the result in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 store, 0 load |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_wdata | input | 32 | Store value, right-aligned |
| req_big | input | 1 | 1 big-endian, 0 little-endian |
| req_signed | input | 1 | Sign-extend loads |
| split_mode | input | 1 | 1 split misaligned, 0 fault |
| mem_valid | output | 1 | Memory transfer request |
| mem_ready | input | 1 | Memory accepts transfer |
| mem_write | output | 1 | Transfer direction |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Lane enables |
| mem_wdata | output | 32 | Lane-placed store data |
| mem_rdata | input | 32 | Read word, valid with mem_ready |
| done | output | 1 | Access complete |
| rdata | output | 32 | Load result |
| misalign_err | output | 1 | Misalignment fault pulse |

## Verification
Fixed stores of 0x12345678 in both byte orders are read back as raw memory words. This separates a correct lane mapping from a reversed or shifted one. Byte and halfword loads at every offset, with both sign settings and a value whose top bit is set, separate correct extraction from wrong lane choice or wrong extension. Misaligned cases are run in both modes: word at offset 2, halfword at offset 3 (two transfers) and halfword at offset 1 (one transfer) in split mode, and a word, a halfword and an always-legal byte in fault mode. These show the transfer order and count, the partial enables and the error pulse. A long pseudo-random mix of sizes, offsets and orders, with memory stalls, is checked against a byte-level reference model.

// File: rtl/endian_lsu.sv
module endian_lsu (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [31:0] req_addr,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_wdata,
  input  logic        req_big,
  input  logic        req_signed,
  input  logic        split_mode,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic        mem_write,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        done,
  output logic [31:0] rdata,
  output logic        misalign_err
);
  typedef enum logic [1:0] {IDLE, ACC0, ACC1} state_t;
  state_t st;

  logic [31:0] a_q, wd_q, lo_q;
  logic [1:0]  sz_q;
  logic        wr_q, big_q, sgn_q;

  logic [2:0]  nb;
  logic [63:0] win, rwin;
  logic [7:0]  be8;
  logic [31:0] ldv, ldx;
  logic        in_mis, need2, xfer;

  assign in_mis = (req_size == 2'd1 && req_addr[0]) || (req_size[1] && req_addr[1:0] != 2'd0);
  assign nb     = (sz_q == 2'd0) ? 3'd1 : (sz_q == 2'd1) ? 3'd2 : 3'd4;
  assign rwin   = (st == ACC1) ? {mem_rdata, lo_q} : {32'h0, mem_rdata};
  assign need2  = |be8[7:4];
  assign xfer   = mem_valid && mem_ready;

  always_comb begin
    logic [2:0] pos;
    win = '0;
    be8 = '0;
    ldv = '0;
    for (int k = 0; k < 4; k++) begin
      pos = 3'(a_q[1:0]) + (big_q ? (nb - 3'(k + 1)) : 3'(k));
      if (3'(k) < nb) begin
        win[{pos, 3'b000} +: 8] = wd_q[k*8 +: 8];
        be8[pos]                = 1'b1;
        ldv[k*8 +: 8]           = rwin[{pos, 3'b000} +: 8];
      end
    end
  end

  always_comb begin
    case (sz_q)
      2'd0:    ldx = {{24{sgn_q & ldv[7]}}, ldv[7:0]};
      2'd1:    ldx = {{16{sgn_q & ldv[15]}}, ldv[15:0]};
      default: ldx = ldv;
    endcase
  end

  assign req_ready = (st == IDLE);
  assign mem_valid = (st != IDLE);
  assign mem_write = wr_q;
  assign mem_addr  = {a_q[31:2] + {29'd0, st == ACC1}, 2'b00};
  assign mem_be    = (st == ACC1) ? be8[7:4] : be8[3:0];
  assign mem_wdata = (st == ACC1) ? win[63:32] : win[31:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= IDLE;
      a_q          <= '0;
      wd_q         <= '0;
      lo_q         <= '0;
      sz_q         <= '0;
      wr_q         <= 1'b0;
      big_q        <= 1'b0;
      sgn_q        <= 1'b0;
      done         <= 1'b0;
      rdata        <= '0;
      misalign_err <= 1'b0;
    end else begin
      done         <= 1'b0;
      misalign_err <= 1'b0;
      case (st)
        IDLE: if (req_valid) begin
          a_q   <= req_addr;
          wd_q  <= req_wdata;
          sz_q  <= req_size;
          wr_q  <= req_write;
          big_q <= req_big;
          sgn_q <= req_signed;
          if (in_mis && !split_mode) misalign_err <= 1'b1;
          else                       st <= ACC0;
        end
        ACC0: if (xfer) begin
          lo_q <= mem_rdata;
          if (need2) st <= ACC1;
          else begin
            st    <= IDLE;
            done  <= 1'b1;
            rdata <= ldx;
          end
        end
        default: if (xfer) begin
          st    <= IDLE;
          done  <= 1'b1;
          rdata <= ldx;
        end
      endcase
    end
  end
endmodule

// File: rtl/endian_lsu_chk.sv
module endian_lsu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic        mem_write,
  input logic [31:0] mem_addr,
  input logic [3:0]  mem_be,
  input logic [31:0] mem_wdata,
  input logic        done,
  input logic        misalign_err
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) $rose(rst_n) |-> req_ready && !mem_valid && !done && !misalign_err);

  // R2
  word_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[1:0] == 2'b00 && mem_be != 4'b0000);

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_be)
                                && $stable(mem_wdata) && $stable(mem_write));

  // R10
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready);

  // R8
  second_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && $past(mem_valid && mem_ready) |-> mem_addr == $past(mem_addr) + 32'd4);

  // R9
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_err |-> !mem_valid && !done);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind endian_lsu endian_lsu_chk u_chk (.*);

// File: tb/endian_lsu_test.sv
module endian_lsu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_big = 1'b0, req_signed = 1'b0, split_mode = 1'b1;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_size = '0;
  logic        req_ready, mem_valid, mem_write, done, misalign_err;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rdata;
  logic [3:0]  mem_be;

  always #5 clk = ~clk;

  endian_lsu uut (.*);

  logic [31:0] mem [16];
  logic [7:0]  bref [64];
  int          rcnt = 0;

  assign mem_rdata = mem[mem_addr[5:2]];

  always @(posedge clk) begin
    rcnt      <= rcnt + 1;
    mem_ready <= rst_n && (rcnt % 3 != 1);
    if (mem_valid && mem_ready && mem_write)
      for (int l = 0; l < 4; l++)
        if (mem_be[l]) mem[mem_addr[5:2]][l*8 +: 8] <= mem_wdata[l*8 +: 8];
  end

  typedef struct {
    bit          err;
    bit          wr;
    logic [31:0] val;
    int          nacc;
    logic [31:0] a0;
    logic [3:0]  be0, be1;
    string       tag;
  } item_t;
  item_t q[$];

  int total = 0, bad = 0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_req(bit wr, logic [31:0] addr, logic [1:0] sz, logic [31:0] data,
                        bit big, bit sgn, bit split, string tag);
    item_t it;
    int n, o, ba;
    bit mis;
    logic [7:0] be8;
    logic [31:0] v;
    n   = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    o   = int'(addr[1:0]);
    mis = (sz == 1 && addr[0]) || (sz >= 2 && o != 0);
    be8 = 8'(((1 << n) - 1) << o);
    it.err  = mis && !split;
    it.wr   = wr;
    it.nacc = it.err ? 0 : ((o + n > 4) ? 2 : 1);
    it.a0   = {addr[31:2], 2'b00};
    it.be0  = be8[3:0];
    it.be1  = be8[7:4];
    it.tag  = tag;
    v = '0;
    for (int k = 0; k < n; k++) begin
      ba = big ? int'(addr[5:0]) + n - 1 - k : int'(addr[5:0]) + k;
      ba = ba % 64;
      if (wr && !it.err) bref[ba] = data[k*8 +: 8];
      v[k*8 +: 8] = bref[ba];
    end
    if (sgn && n == 1) v[31:8]  = {24{v[7]}};
    if (sgn && n == 2) v[31:16] = {16{v[15]}};
    it.val = v;
    q.push_back(it);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_size = sz;
    req_wdata = data; req_big = big; req_signed = sgn; split_mode = split;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  int          hs = 0;
  bit          busy_bad = 0;
  logic [31:0] ma0, ma1;
  logic [3:0]  mb0, mb1;

  always @(negedge clk) if (rst_n) begin
    if (mem_valid && req_ready) busy_bad = 1;
    if (mem_valid && mem_ready) begin
      if (hs == 0) begin ma0 = mem_addr; mb0 = mem_be; end
      else begin ma1 = mem_addr; mb1 = mem_be; end
      hs++;
    end
    if (done || misalign_err) begin
      if (q.size() == 0) chk(0, "R11", "unexpected result", 32'(done), 0);
      else begin
        item_t it;
        it = q.pop_front();
        chk(misalign_err == it.err, it.err ? "R9" : "R7", {it.tag, " error flag"}, 32'(misalign_err), 32'(it.err));
        chk(hs == it.nacc, it.err ? "R9" : "R8", {it.tag, " transfer count"}, hs, it.nacc);
        chk(!busy_bad, "R10", {it.tag, " ready while busy"}, 32'(busy_bad), 0);
        if (it.nacc >= 1) begin
          chk(ma0 == it.a0, "R8", {it.tag, " first address"}, ma0, it.a0);
          chk(mb0 == it.be0, "R2", {it.tag, " first enables"}, 32'(mb0), 32'(it.be0));
        end
        if (it.nacc == 2) begin
          chk(ma1 == it.a0 + 4, "R8", {it.tag, " second address"}, ma1, it.a0 + 4);
          chk(mb1 == it.be1, "R2", {it.tag, " second enables"}, 32'(mb1), 32'(it.be1));
        end
        if (!it.wr && !it.err)
          chk(rdata == it.val, "R5", {it.tag, " load data"}, rdata, it.val);
      end
      hs = 0;
      busy_bad = 0;
    end
  end

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) bref[i] = 8'(i * 7 + 3);
    for (int w = 0; w < 16; w++)
      mem[w] = {bref[4*w+3], bref[4*w+2], bref[4*w+1], bref[4*w]};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready && !mem_valid && !done && !misalign_err, "R1", "reset outputs",
        {28'd0, req_ready, mem_valid, done, misalign_err}, 32'h8);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    do_req(1, 32'h10, 2, 32'h12345678, 0, 0, 1, "R3 LE word store");
    do_req(1, 32'h20, 2, 32'h12345678, 1, 0, 1, "R4 BE word store");
    drain();
    chk(mem[4] == 32'h12345678, "R3", "LE memory word", mem[4], 32'h12345678);
    chk(mem[8] == 32'h78563412, "R4", "BE memory word", mem[8], 32'h78563412);

    do_req(0, 32'h20, 2, 0, 0, 0, 1, "R3 LE word load");
    do_req(0, 32'h20, 2, 0, 1, 0, 1, "R4 BE word load");
    do_req(0, 32'h10, 0, 0, 0, 0, 1, "R5 byte off0");
    do_req(0, 32'h13, 0, 0, 0, 0, 1, "R5 byte off3");
    do_req(1, 32'h30, 1, 32'h8001, 1, 0, 1, "R4 BE half store");
    do_req(0, 32'h30, 1, 0, 0, 1, 1, "R6 LE half signed");
    do_req(0, 32'h30, 1, 0, 1, 1, 1, "R6 BE half signed");
    do_req(0, 32'h30, 1, 0, 1, 0, 1, "R5 BE half unsigned");
    do_req(0, 32'h30, 0, 0, 0, 1, 1, "R6 byte signed");
    do_req(1, 32'h0E, 2, 32'hAABBCCDD, 0, 0, 1, "R8 split word store");
    do_req(0, 32'h0E, 2, 0, 1, 0, 1, "R8 split word load");
    do_req(1, 32'h0B, 1, 32'hBEEF, 0, 0, 1, "R8 split half store");
    do_req(0, 32'h0B, 1, 0, 0, 0, 1, "R8 split half load");
    do_req(0, 32'h05, 1, 0, 1, 1, 1, "R8 odd half one word");
    do_req(0, 32'h01, 2, 0, 0, 0, 0, "R9 fault word");
    do_req(1, 32'h03, 1, 32'h5A5A, 0, 0, 0, "R9 fault half store");
    do_req(0, 32'h03, 2, 0, 0, 0, 1, "R9 store left memory");
    do_req(0, 32'h07, 0, 0, 0, 1, 0, "R7 byte never faults");
    do_req(0, 32'h06, 1, 0, 1, 0, 0, "R7 even half in fault mode");
    drain();

    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      r = $urandom;
      do_req(r[0], {26'd0, r[6:1]}, r[8:7], $urandom, r[9], r[10], r[11], "R11 mixed");
    end
    drain();
    for (int w = 0; w < 16; w++)
      chk(mem[w] == {bref[4*w+3], bref[4*w+2], bref[4*w+1], bref[4*w]}, "R3", "final memory",
          mem[w], {bref[4*w+3], bref[4*w+2], bref[4*w+1], bref[4*w]});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule